// File: doc/BRIEF.md
# Low-Voltage Reset Sequencer

This block is the digital back end of a supply monitor. An external comparator reports, as a single raw bit, that the supply has fallen below the trip level. The block samples that bit into the local clock domain and filters out short spikes. When a low-supply event is accepted, it sets a sticky cause flag and issues a fixed-width internal reset request. Software can read the flag after the reset to learn why the reset happened. The flag goes back to zero only when software writes to clear it.

The reset request is not issued while an internal RAM write is in progress. The block waits in a holding state until the write completes and then starts the pulse. The block keeps running while the device is in stop mode. An event accepted in stop mode also produces a one-cycle wake pulse that takes the device out of stop. While some other internal reset source is driving reset, this block's request output is masked. The pulse still keeps its original timing, so the masking never lengthens it.

The controller has three states:
- `ST_IDLE`: armed and waiting.
- `ST_HOLD`: an event has been accepted and the block is waiting for the RAM write to finish.
- `ST_PULSE`: the reset request is being counted out.

The transitions are:
- `ST_IDLE` goes to `ST_PULSE` on an accepted event when no write is in progress.
- `ST_IDLE` goes to `ST_HOLD` on an accepted event while a write is in progress.
- `ST_HOLD` goes to `ST_PULSE` on the first clock that samples the write as finished.
- `ST_PULSE` goes to `ST_IDLE` after the last pulse cycle.

Top module: `lvd_reset_seq`

## Requirements
- R1: The comparator input passes through SYNC_STAGES (2) flip-flops. An event is accepted only when the synchronized level has been high for FILTER_CYCLES (2) consecutive clocks. An input that is high for a single clock is never accepted. With the defaults, input driven high before edge k causes acceptance at edge k+3.
- R2: `lv_flag` reads 1 starting in the cycle after acceptance. A one-cycle `flag_clr_wr` returns it to 0. If an acceptance and a clear land on the same edge, the flag is set.
- R3: `lv_flag` stays 1 after the reset pulse ends and after the comparator input falls. Only `flag_clr_wr` or `rst_n` clears it.
- R4: With no RAM write in progress, `rst_req` is 1 for exactly PULSE_CYCLES (5) consecutive cycles, starting in the cycle after acceptance.
- R5: If `ram_wr_busy` is 1 at acceptance, `rst_req` stays 0 until the first edge that samples `ram_wr_busy` as 0. The full pulse begins in the cycle after that edge.
- R6: `stop_release` is a one-cycle pulse in the cycle after an acceptance that saw `stop_mode` = 1. In all other cycles it is 0.
- R7: `rst_req` is 0 in every cycle where `other_rst_active` is 1. The pulse window is neither shifted nor extended by this masking.
- R8: A sustained low-supply level produces exactly one pulse. Detections during `ST_HOLD` or `ST_PULSE` start no new pulse. A new pulse requires the input to fall and qualify again.
- R9: While `rst_n` is 0, and in the first cycle after it is released, `rst_req`, `stop_release` and `lv_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| lv_det_raw | input | 1 | Raw comparator output, 1 = supply below threshold |
| stop_mode | input | 1 | Device is in stop mode |
| ram_wr_busy | input | 1 | Internal RAM write cycle in progress |
| other_rst_active | input | 1 | Another internal reset source is currently driving reset |
| flag_clr_wr | input | 1 | Software write of 0 to the cause flag |
| rst_req | output | 1 | Internal reset request |
| stop_release | output | 1 | One-cycle wake request out of stop mode |
| lv_flag | output | 1 | Sticky low-voltage cause flag |

## Verification
The bench targets the following corner cases:
- A one-clock spike on the comparator input. A filter that is off by one would reset the chip on noise.
- A supply that stays low for a long time. A design that re-arms on level rather than on a new episode would emit a train of resets.
- A RAM write that is still in progress at acceptance. A design that ignores it would cut the write off mid-cycle.
- An external reset that overlaps the pulse. A design that stalls its counter here would stretch the reset, and one that ignores the overlap would drive reset twice.
- A flag clear that coincides with a new detection. If the clear wins, the record of the reset cause is lost.

// File: rtl/lvd_pkg.sv
`timescale 1ns/1ps
package lvd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_PULSE = 2'd2
    } lvd_state_e;
endpackage

// File: rtl/lvd_sync.sv
`timescale 1ns/1ps
module lvd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_raw,
    output logic d_sync
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d_raw;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_raw};
            end
        end
    endgenerate

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/lvd_filter.sv
`timescale 1ns/1ps
module lvd_filter #(
    parameter int FILTER_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_s,
    output logic det_evt
);
    localparam int CW = $clog2(FILTER_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(FILTER_CYCLES - 1);
    localparam logic [CW-1:0] SAT  = CW'(FILTER_CYCLES);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             run_cnt <= '0;
        else if (!det_s)        run_cnt <= '0;
        else if (run_cnt != SAT) run_cnt <= run_cnt + 1'b1;
    end

    // one event per qualified episode: the cycle the run reaches its length
    assign det_evt = det_s && (run_cnt == LAST);

    generate
        if (FILTER_CYCLES >= 2) begin : g_chk
            a_r1_evt_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
                det_evt |-> $past(det_s));
        end
    endgenerate
endmodule

// File: rtl/lvd_fsm.sv
`timescale 1ns/1ps
module lvd_fsm
    import lvd_pkg::*;
#(
    parameter int PULSE_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_evt,
    input  logic ram_wr_busy,
    input  logic stop_mode,
    input  logic other_rst_active,
    input  logic flag_clr_wr,
    output logic rst_req,
    output logic stop_release,
    output logic lv_flag
);
    localparam int PCW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [PCW-1:0] PLAST = PCW'(PULSE_CYCLES - 1);

    lvd_state_e state, state_n;
    logic [PCW-1:0] pcnt;
    logic           flag_q;
    logic           wake_q;
    logic           accept;

    assign accept = (state == ST_IDLE) && det_evt;

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (det_evt)          state_n = ram_wr_busy ? ST_HOLD : ST_PULSE;
            ST_HOLD:  if (!ram_wr_busy)     state_n = ST_PULSE;
            ST_PULSE: if (pcnt == PLAST)    state_n = ST_IDLE;
            default:                        state_n = ST_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            pcnt   <= '0;
            flag_q <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            state  <= state_n;
            pcnt   <= (state == ST_PULSE) ? pcnt + 1'b1 : '0;
            wake_q <= accept && stop_mode;
            if (det_evt)          flag_q <= 1'b1;
            else if (flag_clr_wr) flag_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        rst_req      = (state == ST_PULSE) && !other_rst_active;
        stop_release = wake_q;
        lv_flag      = flag_q;
    end

    a_r2_flag_on_evt: assert property (@(posedge clk) disable iff (!rst_n)
        det_evt |=> flag_q);
    a_r4_pulse_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !ram_wr_busy) |=> (state == ST_PULSE && pcnt == '0));
    a_r5_hold_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ram_wr_busy) |=> (state == ST_HOLD));
    a_r6_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |=> !wake_q);
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE && pcnt != '0) |-> ($past(state) == ST_PULSE && pcnt == PCW'($past(pcnt) + 1'b1)));
endmodule

// File: rtl/lvd_reset_seq.sv
`timescale 1ns/1ps
module lvd_reset_seq #(
    parameter int SYNC_STAGES   = 2,
    parameter int FILTER_CYCLES = 2,
    parameter int PULSE_CYCLES  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lv_det_raw,
    input  logic stop_mode,
    input  logic ram_wr_busy,
    input  logic other_rst_active,
    input  logic flag_clr_wr,
    output logic rst_req,
    output logic stop_release,
    output logic lv_flag
);
    logic det_s;
    logic det_evt;

    lvd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_raw(lv_det_raw), .d_sync(det_s)
    );

    lvd_filter #(.FILTER_CYCLES(FILTER_CYCLES)) u_filt (
        .clk(clk), .rst_n(rst_n), .det_s(det_s), .det_evt(det_evt)
    );

    lvd_fsm #(.PULSE_CYCLES(PULSE_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .det_evt(det_evt),
        .ram_wr_busy(ram_wr_busy), .stop_mode(stop_mode),
        .other_rst_active(other_rst_active), .flag_clr_wr(flag_clr_wr),
        .rst_req(rst_req), .stop_release(stop_release), .lv_flag(lv_flag)
    );

    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (lv_flag && !flag_clr_wr) |=> lv_flag);
    a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
        other_rst_active |-> !rst_req);
endmodule

// File: tb/sim_lvd_reset_seq.sv
`timescale 1ns/1ps
module sim_lvd_reset_seq;
    localparam int FILT  = 2;
    localparam int PULSE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lv_det_raw = 1'b0, stop_mode = 1'b0, ram_wr_busy = 1'b0;
    logic other_rst_active = 1'b0, flag_clr_wr = 1'b0;
    logic rst_req, stop_release, lv_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lvd_reset_seq u0 (
        .clk(clk), .rst_n(rst_n), .lv_det_raw(lv_det_raw), .stop_mode(stop_mode),
        .ram_wr_busy(ram_wr_busy), .other_rst_active(other_rst_active),
        .flag_clr_wr(flag_clr_wr), .rst_req(rst_req),
        .stop_release(stop_release), .lv_flag(lv_flag)
    );

    // behavioural reference model
    int m_s1, m_s2, m_run, m_st, m_pc;
    bit m_flag, m_wake, m_evt, m_acc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_run = 0; m_st = 0; m_pc = 0;
            m_flag = 0; m_wake = 0;
        end else begin
            m_evt = (m_s2 != 0) && (m_run == FILT - 1);
            m_acc = (m_st == 0) && m_evt;
            m_wake = m_acc && stop_mode;
            if (m_evt) m_flag = 1;
            else if (flag_clr_wr) m_flag = 0;
            case (m_st)
                0: if (m_acc) begin m_st = ram_wr_busy ? 1 : 2; m_pc = 0; end
                1: if (!ram_wr_busy) begin m_st = 2; m_pc = 0; end
                default: if (m_pc == PULSE - 1) begin m_st = 0; m_pc = 0; end
                         else m_pc = m_pc + 1;
            endcase
            if (m_s2 == 0) m_run = 0;
            else if (m_run < FILT) m_run = m_run + 1;
            m_s2 = m_s1;
            m_s1 = lv_det_raw ? 1 : 0;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // advance one cycle and compare against the model away from the edge
    task automatic step();
        @(negedge clk);
        chk("R4 rst_req vs model", rst_req, (m_st == 2) && !other_rst_active);
        chk("R2 lv_flag vs model", lv_flag, m_flag);
        chk("R6 stop_release vs model", stop_release, m_wake);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic clear_flag();
        flag_clr_wr = 1'b1; step(); flag_clr_wr = 1'b0; step();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        steps(3);
        chk("R9 reset rst_req", rst_req, 1'b0);
        chk("R9 reset lv_flag", lv_flag, 1'b0);
        rst_n = 1'b1;
        step();
        chk("R9 after release stop_release", stop_release, 1'b0);
        chk("R9 after release lv_flag", lv_flag, 1'b0);

        // R1: single-cycle spike rejected
        lv_det_raw = 1'b1; step(); lv_det_raw = 1'b0;
        steps(8);
        chk("R1 spike no flag", lv_flag, 1'b0);
        chk("R1 spike no reset", rst_req, 1'b0);

        // R1/R4/R8: sustained low supply
        lv_det_raw = 1'b1;
        steps(3);
        chk("R1 not yet accepted", rst_req, 1'b0);
        step();
        chk("R4 pulse starts", rst_req, 1'b1);
        chk("R2 flag set", lv_flag, 1'b1);
        steps(4);
        chk("R4 pulse last cycle", rst_req, 1'b1);
        step();
        chk("R4 pulse ended", rst_req, 1'b0);
        steps(12);
        chk("R8 no second pulse", rst_req, 1'b0);
        lv_det_raw = 1'b0;
        steps(6);
        chk("R3 flag survives", lv_flag, 1'b1);
        clear_flag();
        chk("R2 flag cleared", lv_flag, 1'b0);

        // R5: RAM write in progress at acceptance
        ram_wr_busy = 1'b1; lv_det_raw = 1'b1;
        steps(4);
        chk("R5 held during write", rst_req, 1'b0);
        steps(3);
        chk("R5 still held", rst_req, 1'b0);
        ram_wr_busy = 1'b0;
        step();
        chk("R5 pulse after write", rst_req, 1'b1);
        steps(4);
        chk("R5 pulse full length", rst_req, 1'b1);
        step();
        chk("R5 pulse over", rst_req, 1'b0);
        lv_det_raw = 1'b0; steps(6); clear_flag();

        // R6: wake from stop mode
        stop_mode = 1'b1; lv_det_raw = 1'b1;
        steps(3);
        chk("R6 no early wake", stop_release, 1'b0);
        step();
        chk("R6 wake pulse", stop_release, 1'b1);
        step();
        chk("R6 wake single cycle", stop_release, 1'b0);
        stop_mode = 1'b0; lv_det_raw = 1'b0; steps(8); clear_flag();

        // R7: masking by another reset
        lv_det_raw = 1'b1;
        steps(4);
        chk("R7 pulse cycle 0", rst_req, 1'b1);
        other_rst_active = 1'b1;
        step();
        chk("R7 masked", rst_req, 1'b0);
        step();
        other_rst_active = 1'b0;
        step();
        chk("R7 resumes", rst_req, 1'b1);
        step();
        step();
        chk("R7 not extended", rst_req, 1'b0);
        lv_det_raw = 1'b0; steps(6);

        // R2: set beats clear on the same edge; R8 re-qualify gives new pulse
        flag_clr_wr = 1'b1; step();
        chk("R2 clear works", lv_flag, 1'b0);
        lv_det_raw = 1'b1;
        steps(4);
        chk("R2 set wins over clear", lv_flag, 1'b1);
        chk("R8 new episode pulses", rst_req, 1'b1);
        flag_clr_wr = 1'b0;
        steps(8);
        lv_det_raw = 1'b0;
        steps(4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule